// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block runs accesses from a processor core onto an asynchronous external memory bus. The bus has a 16-bit address and 16-bit data. The core presents one request at a time: an address, write data, a read/write flag, a space flag (program or data) and a flag that marks the access as internal. For an external request the block drives the address and write data and asserts the read or write strobe. It also asserts the strobe for the space the access belongs to. All strobes are active low. The block holds the core off with a ready output until the access ends.

Program space and data space each have their own 2-bit wait setting, which selects 0, 4, 8 or 12 wait states. Each wait state lengthens the access by two clock periods. An internal access never starts a bus cycle and never lowers ready. After each access the bus stays in a one-cycle hold. In the hold cycle the read and write strobes are released while the address and space strobe are kept. Ready is high in the hold cycle, and a request presented then starts at the end of it.

Top module: `ext_bus_waitgen`

## Requirements
- R1: After synchronous reset, core_ready is 1, bus_rd_n, bus_wr_n, bus_ps_n and bus_ds_n are 1, and bus_addr and rd_data are 0.
- R2: When core_ready is 1, a request with req_valid=1 and req_internal=0 is taken at the clock edge. From the next cycle core_ready is 0 and bus_addr equals req_addr.
- R3: The read or write strobe stays low for 1 + 8*code consecutive cycles, and core_ready stays low for exactly those cycles. The code is the 2-bit setting of the access's space: 00 gives 0 wait states, 01 gives 4, 10 gives 8 and 11 gives 12. Each wait state costs 2 clocks.
- R4: req_space=1 selects program space. That access uses ws_prog and drives bus_ps_n low. req_space=0 selects data space, uses ws_data and drives bus_ds_n low. The two space strobes are never low together.
- R5: A read (req_write=0) drives only bus_rd_n low. The block samples bus_din in the last strobe cycle. The sampled value appears on rd_data from the completion cycle and stays there until the next read completes.
- R6: bus_addr, the active space strobe and bus_dout stay constant for every cycle of an access.
- R7: A write (req_write=1) drives only bus_wr_n low, and bus_dout carries req_wdata. In the cycle after the last strobe cycle (the hold cycle), bus_wr_n and bus_rd_n are 1. In that cycle bus_addr and the space strobe are unchanged and core_ready is 1.
- R8: A request with req_internal=1 is ignored: core_ready stays 1, no strobe falls and bus_addr is unchanged.
- R9: The wait setting is taken when the access starts. A change of ws_prog or ws_data during an access does not change its length.
- R10: A request presented during the hold cycle is taken at the end of that cycle. Back-to-back accesses therefore start 2 + 8*code cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core presents a request |
| req_internal | input | 1 | Request targets internal memory, no bus cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 1 | 1 = program space, 0 = data space |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| ws_prog | input | 2 | Wait setting for program space |
| ws_data | input | 2 | Wait setting for data space |
| core_ready | output | 1 | 1 when the block can take a request |
| rd_data | output | 16 | Data of the last completed read |
| bus_addr | output | 16 | External address |
| bus_dout | output | 16 | External write data |
| bus_din | input | 16 | External read data |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ps_n | output | 1 | Program-space strobe, active low |
| bus_ds_n | output | 1 | Data-space strobe, active low |

## Verification
The bench builds the block with its default parameters: 16-bit buses, a 2-bit setting in steps of 4 wait states, and 2 clocks per wait state. These values make the whole range reachable, from the single-cycle access up to the 25-cycle stretch. All four settings are tried in both spaces, including cases where program and data settings differ. Back-to-back accesses taken in the hold cycle, a setting changed in the middle of an access, and internal requests arriving between bus cycles are also reached.

// File: rtl/ebw_pkg.sv
package ebw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACT  = 2'd1,
    PH_HOLD = 2'd2
  } phase_t;
endpackage

// File: rtl/ebw_wait_decode.sv
module ebw_wait_decode #(
  parameter int WSW        = 2,
  parameter int WS_STEP    = 4,
  parameter int CLK_PER_WS = 2,
  parameter int CW         = 5
) (
  input  logic [WSW-1:0] code,
  output logic [CW-1:0]  last_idx
);
  localparam int STRETCH = WS_STEP * CLK_PER_WS;
  // last_idx = cycles beyond the base cycle (length - 1)
  assign last_idx = CW'(STRETCH * int'(code));
endmodule

// File: rtl/ebw_seq.sv
module ebw_seq #(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int CW      = 5,
  parameter int MAX_LEN = 25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_internal,
  input  logic          req_write,
  input  logic          req_space,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [CW-1:0] last_idx,
  input  logic [DW-1:0] bus_din,
  output logic          core_ready,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic          bus_ps_n,
  output logic          bus_ds_n
);
  import ebw_pkg::*;

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic          wr_q;
  logic          accept;

  assign accept = req_valid && !req_internal && (ph != PH_ACT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_IDLE;
      cnt        <= '0;
      wr_q       <= 1'b0;
      core_ready <= 1'b1;
      rd_data    <= '0;
      bus_addr   <= '0;
      bus_dout   <= '0;
      bus_rd_n   <= 1'b1;
      bus_wr_n   <= 1'b1;
      bus_ps_n   <= 1'b1;
      bus_ds_n   <= 1'b1;
    end else begin
      case (ph)
        PH_ACT: begin
          if (cnt == '0) begin
            ph         <= PH_HOLD;
            core_ready <= 1'b1;
            bus_rd_n   <= 1'b1;
            bus_wr_n   <= 1'b1;
            if (!wr_q) rd_data <= bus_din;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (accept) begin
            ph         <= PH_ACT;
            cnt        <= last_idx;
            wr_q       <= req_write;
            core_ready <= 1'b0;
            bus_addr   <= req_addr;
            bus_dout   <= req_wdata;
            bus_rd_n   <= req_write;
            bus_wr_n   <= !req_write;
            bus_ps_n   <= !req_space;
            bus_ds_n   <= req_space;
          end else if (ph == PH_HOLD) begin
            ph       <= PH_IDLE;
            bus_ps_n <= 1'b1;
            bus_ds_n <= 1'b1;
          end
        end
      endcase
    end
  end

  // checker counter: length of the current low-ready stretch
  logic [7:0] low_run;
  always_ff @(posedge clk) begin
    if (rst)              low_run <= '0;
    else if (!core_ready) low_run <= low_run + 1'b1;
    else                  low_run <= '0;
  end

  AST_SPACE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({!bus_ps_n, !bus_ds_n}));                                       // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && !bus_wr_n));                                              // R5
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    !core_ready |=> ($stable(bus_addr) && $stable(bus_dout)));               // R6
  AST_WR_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |=> (!bus_wr_n || (core_ready && $stable(bus_addr))));        // R7
  AST_START_STROBE: assert property (@(posedge clk) disable iff (rst)
    $fell(core_ready) |-> (bus_rd_n != bus_wr_n));                           // R2
  AST_INTERNAL_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (core_ready && req_valid && req_internal) |=> core_ready);               // R8
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(low_run) <= MAX_LEN);                                               // R3
endmodule

// File: rtl/ext_bus_waitgen.sv
module ext_bus_waitgen #(
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int WSW        = 2,
  parameter int WS_STEP    = 4,
  parameter int CLK_PER_WS = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic           req_internal,
  input  logic           req_write,
  input  logic           req_space,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [WSW-1:0] ws_prog,
  input  logic [WSW-1:0] ws_data,
  output logic           core_ready,
  output logic [DW-1:0]  rd_data,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_dout,
  input  logic [DW-1:0]  bus_din,
  output logic           bus_rd_n,
  output logic           bus_wr_n,
  output logic           bus_ps_n,
  output logic           bus_ds_n
);
  localparam int MAX_LAST = CLK_PER_WS * WS_STEP * ((1 << WSW) - 1);
  localparam int CW       = $clog2(MAX_LAST + 1);
  localparam int NSPACE   = 2;   // index 0 = data, 1 = program

  logic [WSW-1:0] codes  [NSPACE];
  logic [CW-1:0]  lasts  [NSPACE];
  logic [CW-1:0]  last_sel;

  assign codes[0] = ws_data;
  assign codes[1] = ws_prog;

  for (genvar s = 0; s < NSPACE; s++) begin : g_space
    ebw_wait_decode #(
      .WSW(WSW), .WS_STEP(WS_STEP), .CLK_PER_WS(CLK_PER_WS), .CW(CW)
    ) u_dec (
      .code     (codes[s]),
      .last_idx (lasts[s])
    );
  end

  assign last_sel = lasts[req_space];

  ebw_seq #(
    .AW(AW), .DW(DW), .CW(CW), .MAX_LEN(MAX_LAST + 1)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_internal (req_internal),
    .req_write    (req_write),
    .req_space    (req_space),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .last_idx     (last_sel),
    .bus_din      (bus_din),
    .core_ready   (core_ready),
    .rd_data      (rd_data),
    .bus_addr     (bus_addr),
    .bus_dout     (bus_dout),
    .bus_rd_n     (bus_rd_n),
    .bus_wr_n     (bus_wr_n),
    .bus_ps_n     (bus_ps_n),
    .bus_ds_n     (bus_ds_n)
  );
endmodule

// File: tb/tb_ext_bus_waitgen.sv
module tb_ext_bus_waitgen;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_internal, req_write, req_space;
  logic [15:0] req_addr, req_wdata;
  logic [1:0]  ws_prog, ws_data;
  logic        core_ready;
  logic [15:0] rd_data, bus_addr, bus_dout, bus_din;
  logic        bus_rd_n, bus_wr_n, bus_ps_n, bus_ds_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [15:0] last_rd = 16'h0;

  always #4 clk = ~clk;   // 125 MHz

  ext_bus_waitgen dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_internal(req_internal),
    .req_write(req_write), .req_space(req_space), .req_addr(req_addr),
    .req_wdata(req_wdata), .ws_prog(ws_prog), .ws_data(ws_data),
    .core_ready(core_ready), .rd_data(rd_data), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_ps_n(bus_ps_n), .bus_ds_n(bus_ds_n)
  );

  function automatic logic [15:0] mem_val(input logic [15:0] a, input logic ps_n);
    return (a * 16'h9E37) ^ (ps_n ? 16'h0F0F : 16'hF0F0);
  endfunction

  function automatic int exp_len(input logic [1:0] code);
    return 1 + 2 * 4 * int'(code);
  endfunction

  assign bus_din = mem_val(bus_addr, bus_ps_n);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // Drives at a negedge; returns at the negedge of the hold cycle.
  task automatic access(input bit w, input bit sp, input logic [15:0] a,
                        input logic [15:0] d, input bit flip);
    int L;
    logic [15:0] a0;
    L = exp_len(sp ? ws_prog : ws_data);
    req_valid = 1'b1; req_internal = 1'b0; req_write = w; req_space = sp;
    req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    a0 = bus_addr;
    chk(core_ready == 1'b0 && bus_addr == a, "R2", {15'd0, core_ready, bus_addr}, {16'd0, a});
    for (int i = 0; i < L; i++) begin
      if (i == 0) chk(bus_addr == a0, "R6", bus_addr, a0);
      chk(core_ready == 1'b0, "R3", core_ready, 0);
      chk(w ? (bus_wr_n == 1'b0 && bus_rd_n == 1'b1) : (bus_rd_n == 1'b0 && bus_wr_n == 1'b1),
          w ? "R7" : "R5", {bus_rd_n, bus_wr_n}, w ? 2'b10 : 2'b01);
      chk(bus_ps_n == !sp && bus_ds_n == sp, "R4", {bus_ps_n, bus_ds_n}, {!sp, sp});
      chk(bus_addr == a && (!w || bus_dout == d), "R6", {bus_addr, bus_dout}, {a, d});
      if (flip && i == 0) begin ws_prog = 2'd0; ws_data = 2'd0; end  // R9
      @(negedge clk);
    end
    // hold cycle
    chk(core_ready == 1'b1, "R3", core_ready, 1);
    chk(bus_rd_n && bus_wr_n && bus_addr == a && bus_ps_n == !sp && bus_ds_n == sp,
        "R7", {bus_rd_n, bus_wr_n, bus_ps_n, bus_ds_n, bus_addr},
        {1'b1, 1'b1, !sp, sp, a});
    if (!w) last_rd = mem_val(a, !sp);
    chk(rd_data == last_rd, "R5", rd_data, last_rd);
  endtask

  task automatic internal_req();
    logic [15:0] a0;
    a0 = bus_addr;
    req_valid = 1'b1; req_internal = 1'b1; req_write = 1'b0;
    req_addr = ~a0;
    @(negedge clk);
    req_valid = 1'b0; req_internal = 1'b0;
    chk(core_ready && bus_rd_n && bus_wr_n && bus_addr == a0, "R8",
        {core_ready, bus_rd_n, bus_wr_n, bus_addr}, {3'b111, a0});
    @(negedge clk);
    chk(core_ready && bus_rd_n && bus_wr_n && bus_addr == a0, "R8",
        {core_ready, bus_rd_n, bus_wr_n, bus_addr}, {3'b111, a0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; req_valid = 0; req_internal = 0; req_write = 0; req_space = 0;
    req_addr = 0; req_wdata = 0; ws_prog = 0; ws_data = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(core_ready && bus_rd_n && bus_wr_n && bus_ps_n && bus_ds_n, "R1",
        {core_ready, bus_rd_n, bus_wr_n, bus_ps_n, bus_ds_n}, 5'b11111);
    chk(bus_addr == 0 && rd_data == 0, "R1", {bus_addr, rd_data}, 0);

    // directed: every code in both spaces, differing settings
    for (int c = 0; c < 4; c++) begin
      ws_prog = 2'(c); ws_data = 2'(3 - c);
      access(1'b0, 1'b1, 16'h1000 + 16'(c), 16'h0, 1'b0);   // R3 R4 program read
      access(1'b1, 1'b0, 16'h2000 + 16'(c), 16'hA500 + 16'(c), 1'b0); // R7 data write
      @(negedge clk);
      access(1'b0, 1'b0, 16'h3000 + 16'(c), 16'h0, 1'b0);   // R5 data read
      @(negedge clk);
    end

    // R9: setting changed mid-access
    ws_prog = 2'd3;
    access(1'b1, 1'b1, 16'h4444, 16'h5A5A, 1'b1);
    chk(ws_prog == 2'd0, "R9", ws_prog, 0);

    // R8: internal requests between bus cycles
    @(negedge clk);
    internal_req();
    ws_data = 2'd1;
    access(1'b0, 1'b0, 16'hBEEF, 16'h0, 1'b0);
    internal_req();

    // R10: back-to-back, next request taken in hold cycle
    ws_data = 2'd0; ws_prog = 2'd2;
    access(1'b1, 1'b0, 16'h0001, 16'h1111, 1'b0);
    access(1'b0, 1'b1, 16'h0002, 16'h0, 1'b0);
    access(1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 1'b0);
    access(1'b0, 1'b0, 16'h0000, 16'h0, 1'b0);

    // random mix
    for (int k = 0; k < 60; k++) begin
      ws_prog = 2'($urandom_range(0, 3));
      ws_data = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 5) == 0) internal_req();
      access(1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom), 1'b0);
      if ($urandom_range(0, 1) == 1) @(negedge clk);
    end

    summary();
  end
endmodule